// File: doc/BRIEF.md
# Tiered Priority Memory Select Decoder

This block turns a 16-bit processor address into at most one memory select per bus cycle. A register file holds one address window per select: an enable bit, a space bit, an inclusive low bound and an inclusive high bound. The selects fall into three tiers. The fast tier holds the scratch SRAM select, the I/O control select and the peripheral window selects. The middle tier holds the secondary flash sectors. The bottom tier holds the main flash sectors.

Windows in different tiers may overlap. The highest tier that matches wins, so only one memory drives the data bus. Windows in the same tier are not supposed to overlap. If they do, the block raises a clash flag and picks the lowest-numbered match so that the output stays one-hot. The flash selects also compare the cycle's space (program or data) against their own space bit. A global remap input moves all main flash into data space and all secondary flash into program space. With this setting, code runs from secondary flash while main flash is rewritten through data cycles.

When the configuration port loads a flash window, it checks the window's size against the physical sector size. It refuses a window that is too large or that has its bounds reversed.

Top module: `memsel_top`

## Requirements
- R1: The tiers rank fast tier, then secondary flash, then main flash. When windows in two or more tiers contain the address, only a select from the highest matching tier is driven. For example, with main 0 at 0x8000–0xBFFF, secondary 0 at 0x8000–0x9FFF and SRAM at 0x8000–0x87FF, the mapping is 0x8000–0x87FF to SRAM, 0x8800–0x9FFF to secondary 0, and 0xA000–0xBFFF to main 0.
- R2: When two or more qualified windows of the winning tier or of any other tier contain the address, `clash_o` is 1 and the lowest-numbered match of the winning tier is selected.
- R3: A window whose enable bit is 0 never matches. When no window matches a strobed address, `sel_o` is all zero and `none_o` is 1.
- R4: A flash window matches only when `space_i` equals its space bit (0 = program, 1 = data). Fast-tier windows ignore `space_i`.
- R5: While `main_data_i` is 1, main flash windows match only data cycles and secondary flash windows match only program cycles, whatever their space bits.
- R6: A write with `cfg_idx_i` at or beyond the number of selects is refused. So is a write with high below low, a secondary window wider than `SEC_BYTES`, or a main window wider than `MAIN_BYTES`. A refused write leaves every window unchanged and sets `cfg_err_o` for the cycle after the write.
- R7: On a rising edge with `strobe_i` high, the decode of `addr_i`, `space_i` and `main_data_i` appears on the outputs with `valid_o` = 1. After an edge with `strobe_i` low, `valid_o`, `sel_o`, `none_o` and `clash_o` are all 0.
- R8: `sel_o` has at most one bit set. Bit k belongs to select k. Selects 0..NT-1 are the fast tier (0 is SRAM, 1 is I/O control, the rest are peripheral windows). Selects NT..NT+NS-1 are secondary sectors. The remaining selects are main sectors.
- R9: Synchronous reset disables every window and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | Bus address |
| strobe_i | input | 1 | Address valid for this cycle |
| space_i | input | 1 | Cycle space, 0 program, 1 data |
| main_data_i | input | 1 | Remap main flash to data and secondary flash to program |
| cfg_we_i | input | 1 | Window write strobe |
| cfg_idx_i | input | 5 | Select number to load |
| cfg_lo_i | input | 16 | Window low bound, inclusive |
| cfg_hi_i | input | 16 | Window high bound, inclusive |
| cfg_en_i | input | 1 | Window enable |
| cfg_dspace_i | input | 1 | Window space bit for flash selects |
| sel_o | output | 16 | One-hot memory select |
| none_o | output | 1 | No window matched |
| clash_o | output | 1 | Same-tier overlap seen |
| valid_o | output | 1 | Outputs hold a decode |
| cfg_err_o | output | 1 | Previous write was refused |

## Verification
The assertions assume that windows are only loaded through the configuration port. They also assume that `addr_i`, `space_i` and `main_data_i` are meaningful only on edges where `strobe_i` is high. The properties relate tier hits sampled on a strobed edge to the select seen one edge later. The bench keeps configuration writes and address sweeps in separate phases, so every strobed address is decoded against a settled set of windows. It sweeps the whole address space or a strided subset under several overlapping layouts, in both spaces and with the remap set and clear.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    parameter int ADDR_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ADDR_W:0]   span_t;

    typedef enum logic {
        SP_PROG = 1'b0,
        SP_DATA = 1'b1
    } space_e;

    typedef struct packed {
        logic  en;
        logic  dspace;
        addr_t lo;
        addr_t hi;
    } window_t;

    function automatic logic win_hit(window_t w, addr_t a);
        return w.en && (a >= w.lo) && (a <= w.hi);
    endfunction

    function automatic logic win_fits(addr_t lo, addr_t hi, span_t limit);
        span_t width;
        width = {1'b0, hi} - {1'b0, lo} + span_t'(1);
        return (hi >= lo) && (width <= limit);
    endfunction

endpackage

// File: rtl/memsel_cfg.sv
module memsel_cfg
    import memsel_pkg::*;
#(
    parameter int    NT         = 4,
    parameter int    NS         = 4,
    parameter int    NM         = 8,
    parameter span_t SEC_BYTES  = span_t'(17'h02000),
    parameter span_t MAIN_BYTES = span_t'(17'h04000),
    localparam int   NSEL       = NT + NS + NM,
    localparam int   IW         = $clog2(NSEL + 1)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IW-1:0]       idx,
    input  addr_t               lo,
    input  addr_t               hi,
    input  logic                en,
    input  logic                dspace,
    output window_t [NSEL-1:0]  wins,
    output logic                err
);

    logic  accept;
    span_t limit;

    // Size limit depends on which tier the index lands in.
    always_comb begin
        if (int'(idx) < NT)           limit = {1'b1, {ADDR_W{1'b0}}};
        else if (int'(idx) < NT + NS) limit = SEC_BYTES;
        else                          limit = MAIN_BYTES;
        accept = (int'(idx) < NSEL) && win_fits(lo, hi, limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wins <= '0;
            err  <= 1'b0;
        end else begin
            err <= we && !accept;
            if (we && accept) begin
                for (int k = 0; k < NSEL; k++) begin
                    if (int'(idx) == k) begin
                        wins[k] <= '{en: en, dspace: dspace, lo: lo, hi: hi};
                    end
                end
            end
        end
    end

    // R6: a refusal is reported only after a write
    a_r6_err_needs_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> !err);

    // R6: a refused write leaves the window file untouched
    a_r6_refusal_keeps: assert property (@(posedge clk) disable iff (rst)
        (we && !accept) |=> (wins == $past(wins)));

endmodule

// File: rtl/memsel_tier.sv
module memsel_tier
    import memsel_pkg::*;
#(
    parameter int N         = 4,
    parameter bit USE_SPACE = 1'b1
)(
    input  window_t [N-1:0] wins,
    input  addr_t           addr,
    input  logic            space,
    input  logic            force_sp,
    input  logic            forced,
    output logic [N-1:0]    first,
    output logic            any,
    output logic            multi
);

    logic [N-1:0] hit;

    for (genvar k = 0; k < N; k++) begin : g_match
        logic want;
        if (USE_SPACE) begin : g_sp
            assign want = forced ? force_sp : wins[k].dspace;
            assign hit[k] = win_hit(wins[k], addr) && (want == space);
        end else begin : g_nosp
            assign want = 1'b0;
            assign hit[k] = win_hit(wins[k], addr);
        end
    end

    assign first = hit & (~hit + N'(1));
    assign any   = |hit;
    assign multi = |(hit & (hit - N'(1)));

endmodule

// File: rtl/memsel_top.sv
module memsel_top
    import memsel_pkg::*;
#(
    parameter int    NT         = 4,
    parameter int    NS         = 4,
    parameter int    NM         = 8,
    parameter span_t SEC_BYTES  = span_t'(17'h02000),
    parameter span_t MAIN_BYTES = span_t'(17'h04000),
    localparam int   NSEL       = NT + NS + NM,
    localparam int   IW         = $clog2(NSEL + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_i,
    input  logic              space_i,
    input  logic              main_data_i,
    input  logic              cfg_we_i,
    input  logic [IW-1:0]     cfg_idx_i,
    input  logic [ADDR_W-1:0] cfg_lo_i,
    input  logic [ADDR_W-1:0] cfg_hi_i,
    input  logic              cfg_en_i,
    input  logic              cfg_dspace_i,
    output logic [NSEL-1:0]   sel_o,
    output logic              none_o,
    output logic              clash_o,
    output logic              valid_o,
    output logic              cfg_err_o
);

    window_t [NSEL-1:0] wins;

    logic [NT-1:0] top_first;
    logic [NS-1:0] sec_first;
    logic [NM-1:0] main_first;
    logic top_any, sec_any, main_any;
    logic top_multi, sec_multi, main_multi;
    logic [NSEL-1:0] pick;

    memsel_cfg #(
        .NT(NT), .NS(NS), .NM(NM),
        .SEC_BYTES(SEC_BYTES), .MAIN_BYTES(MAIN_BYTES)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we_i), .idx(cfg_idx_i),
        .lo(cfg_lo_i), .hi(cfg_hi_i), .en(cfg_en_i), .dspace(cfg_dspace_i),
        .wins(wins), .err(cfg_err_o)
    );

    memsel_tier #(.N(NT), .USE_SPACE(1'b0)) u_top (
        .wins(wins[NT-1:0]), .addr(addr_i), .space(space_i),
        .force_sp(1'b0), .forced(1'b0),
        .first(top_first), .any(top_any), .multi(top_multi)
    );

    memsel_tier #(.N(NS), .USE_SPACE(1'b1)) u_sec (
        .wins(wins[NT+NS-1:NT]), .addr(addr_i), .space(space_i),
        .force_sp(SP_PROG), .forced(main_data_i),
        .first(sec_first), .any(sec_any), .multi(sec_multi)
    );

    memsel_tier #(.N(NM), .USE_SPACE(1'b1)) u_main (
        .wins(wins[NSEL-1:NT+NS]), .addr(addr_i), .space(space_i),
        .force_sp(SP_DATA), .forced(main_data_i),
        .first(main_first), .any(main_any), .multi(main_multi)
    );

    // Fixed tier ranking: fast tier, then secondary, then main.
    always_comb begin
        pick = '0;
        if (top_any)      pick[NT-1:0]        = top_first;
        else if (sec_any) pick[NT+NS-1:NT]    = sec_first;
        else              pick[NSEL-1:NT+NS]  = main_first;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_o   <= '0;
            none_o  <= 1'b0;
            clash_o <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= strobe_i;
            sel_o   <= strobe_i ? pick : '0;
            none_o  <= strobe_i && !(top_any || sec_any || main_any);
            clash_o <= strobe_i && (top_multi || sec_multi || main_multi);
        end
    end

    // R8: never more than one memory driven
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $onehot0(sel_o));

    // R3: no-match flag agrees with an empty select
    a_r3_none_empty: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (none_o == (sel_o == '0)));

    // R7: an unstrobed edge leaves all outputs quiet
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> (!valid_o && sel_o == '0 && !none_o && !clash_o));

    // R1: a fast-tier hit always owns the cycle
    a_r1_top_wins: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && top_any) |=> (sel_o[NT-1:0] != '0));

    // R1: secondary flash beats main flash
    a_r1_sec_over_main: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && !top_any && sec_any) |=> (sel_o[NT+NS-1:NT] != '0));

endmodule

// File: tb/sim_memsel_top.sv
module sim_memsel_top;

    localparam int NT   = 4;
    localparam int NS   = 4;
    localparam int NM   = 8;
    localparam int NSEL = NT + NS + NM;
    localparam int IW   = $clog2(NSEL + 1);
    localparam int SEC_LIM  = 32'h2000;
    localparam int MAIN_LIM = 32'h4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] addr = '0;
    logic strobe = 1'b0, space = 1'b0, main_data = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_ds = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [15:0] cfg_lo = '0, cfg_hi = '0;
    logic [NSEL-1:0] sel;
    logic none, clash, valid, cfg_err;

    always #10 clk = ~clk;

    memsel_top u0 (
        .clk(clk), .rst(rst), .addr_i(addr), .strobe_i(strobe),
        .space_i(space), .main_data_i(main_data),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_lo_i(cfg_lo),
        .cfg_hi_i(cfg_hi), .cfg_en_i(cfg_en), .cfg_dspace_i(cfg_ds),
        .sel_o(sel), .none_o(none), .clash_o(clash), .valid_o(valid),
        .cfg_err_o(cfg_err)
    );

    typedef struct packed {
        logic [NSEL-1:0] sel;
        logic            none;
        logic            clash;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic        m_en[NSEL];
    logic        m_ds[NSEL];
    logic [15:0] m_lo[NSEL];
    logic [15:0] m_hi[NSEL];

    function automatic exp_t model(logic [15:0] a, logic sp, logic rc);
        exp_t e;
        int base[3];
        int cnt[3];
        int firsthit[3];
        e = '0;
        base[0] = 0; base[1] = NT; base[2] = NT + NS;
        cnt[0] = NT; cnt[1] = NS; cnt[2] = NM;
        for (int t = 0; t < 3; t++) begin
            int n;
            n = 0;
            firsthit[t] = -1;
            for (int k = 0; k < cnt[t]; k++) begin
                int g;
                logic want, ok;
                g = base[t] + k;
                want = m_ds[g];
                if (rc && t == 1) want = 1'b0;
                if (rc && t == 2) want = 1'b1;
                ok = m_en[g] && a >= m_lo[g] && a <= m_hi[g] && (t == 0 || want == sp);
                if (ok) begin
                    if (firsthit[t] < 0) firsthit[t] = g;
                    n++;
                end
            end
            if (n > 1) e.clash = 1'b1;
        end
        if (firsthit[0] >= 0)      e.sel[firsthit[0]] = 1'b1;
        else if (firsthit[1] >= 0) e.sel[firsthit[1]] = 1'b1;
        else if (firsthit[2] >= 0) e.sel[firsthit[2]] = 1'b1;
        e.none = (e.sel == '0);
        return e;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: pops one expectation per valid output
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R7 unexpected valid", 32'(valid), 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(sel == e.sel, "R1 select", 32'(sel), 32'(e.sel));
                check(clash == e.clash, "R2 clash", 32'(clash), 32'(e.clash));
                check(none == e.none, "R3 none", 32'(none), 32'(e.none));
            end
        end
    end

    task automatic cfg_write(int idx, logic [15:0] lo, logic [15:0] hi,
                             logic en, logic ds, logic expect_ok);
        logic [31:0] lim, width;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_lo = lo; cfg_hi = hi;
        cfg_en = en; cfg_ds = ds;
        @(negedge clk);
        cfg_we = 1'b0;
        lim = (idx < NT) ? 32'h10000 : (idx < NT + NS) ? SEC_LIM : MAIN_LIM;
        width = 32'(hi) - 32'(lo) + 32'd1;
        if (idx < NSEL && hi >= lo && width <= lim) begin
            m_en[idx] = en; m_ds[idx] = ds; m_lo[idx] = lo; m_hi[idx] = hi;
        end
        // R6: error flag seen one cycle after the write
        check(cfg_err == !expect_ok, "R6 cfg_err", 32'(cfg_err), 32'(!expect_ok));
    endtask

    task automatic sweep(int start, int stride, int count, logic sp, logic rc);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            addr = 16'(start + i * stride);
            space = sp; main_data = rc; strobe = 1'b1;
            q.push_back(model(addr, sp, rc));
        end
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        // R7: quiet after an unstrobed edge
        check(!valid && sel == '0 && !none && !clash, "R7 idle",
              32'({valid, none, clash}), 32'd0);
    endtask

    initial begin
        for (int k = 0; k < NSEL; k++) begin
            m_en[k] = 1'b0; m_ds[k] = 1'b0; m_lo[k] = '0; m_hi[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: outputs clear after reset
        check(sel == '0 && !valid && !none && !clash && !cfg_err, "R9 reset outputs",
              32'({sel, valid, none, clash}), 32'd0);
        // R9: all windows disabled, so every address misses
        sweep(16'h0000, 16'h1111, 16, 1'b0, 1'b0);

        // Layout A: nested windows of the three tiers, plus same-tier overlap
        cfg_write(NT + NS + 0, 16'h8000, 16'hBFFF, 1'b1, 1'b0, 1'b1);
        cfg_write(NT + 0,      16'h8000, 16'h9FFF, 1'b1, 1'b0, 1'b1);
        cfg_write(0,           16'h8000, 16'h87FF, 1'b1, 1'b0, 1'b1);
        cfg_write(1,           16'h0000, 16'h00FF, 1'b1, 1'b0, 1'b1);
        cfg_write(2,           16'hF000, 16'hF0FF, 1'b1, 1'b0, 1'b1);
        cfg_write(NT + 1,      16'hE000, 16'hFFFF, 1'b1, 1'b0, 1'b1);
        cfg_write(NT + NS + 1, 16'hC000, 16'hFFFF, 1'b1, 1'b0, 1'b1);
        cfg_write(NT + NS + 2, 16'h0000, 16'h3FFF, 1'b1, 1'b0, 1'b1);
        cfg_write(NT + NS + 3, 16'h2000, 16'h5FFF, 1'b1, 1'b0, 1'b1);
        cfg_write(NT + 2,      16'h4000, 16'h5FFF, 1'b1, 1'b1, 1'b1);
        cfg_write(NT + NS + 4, 16'h6000, 16'h7FFF, 1'b1, 1'b1, 1'b1);

        // R6: refused writes leave the layout as it was
        cfg_write(NT + NS + 5, 16'h0000, 16'h7FFF, 1'b1, 1'b0, 1'b0);
        cfg_write(NT + 3,      16'h0000, 16'h3FFF, 1'b1, 1'b0, 1'b0);
        cfg_write(0,           16'h9000, 16'h8000, 1'b1, 1'b0, 1'b0);
        cfg_write(NSEL,        16'h0000, 16'h0001, 1'b1, 1'b0, 1'b0);
        sweep(16'h7000, 16'h0100, 32, 1'b0, 1'b0);

        // R1 R2 R3 R4: full program-space sweep
        sweep(0, 1, 65536, 1'b0, 1'b0);
        // R4: data-space cycles
        sweep(0, 4, 16384, 1'b1, 1'b0);
        // R5: remap on, both spaces
        sweep(1, 4, 16384, 1'b0, 1'b1);
        sweep(2, 4, 16384, 1'b1, 1'b1);

        // Layout B: fast-tier clash, SRAM disabled (R3)
        cfg_write(0, 16'h8000, 16'h87FF, 1'b0, 1'b0, 1'b1);
        cfg_write(3, 16'h0080, 16'h01FF, 1'b1, 1'b0, 1'b1);
        sweep(0, 2, 32768, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R7 pending results", 32'(q.size()), 32'd0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule